// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits between an interrupt source controller and one processor core. It keeps a single pending-interrupt slot, holding a source number and the priority it arrived with, and drives one interrupt line to the core that is high whenever the slot is occupied. The source controller offers interrupts one at a time over a valid/ready channel. Each offer receives an admit or refuse answer one cycle later. An admitted offer may push out an interrupt that was already pending, and the pushed-out source number is returned to the sources on a separate bounce port so it can be offered again later.

The core reaches the block through a one-operation-per-cycle register port. It can acknowledge (take the pending interrupt and raise its own priority to match), peek without side effects, set its current priority, set the priority of the inter-processor request, or signal completion of an interrupt. The inter-processor request has no slot of its own. When its priority beats the core's priority and whatever is pending, it claims the pending slot under the reserved source number 2. Whenever the slot is found empty after a priority change or a completion, the block pulses a resend request so that the sources offer refused interrupts again.

Priorities are 8-bit numbers where a smaller value is more favoured, and 0xFF means masked or least favoured. The pending word read by the core is 32 bits: bits 31:24 hold the current processor priority and bits 23:0 hold the pending source number, with 0 meaning nothing is pending. Source numbers offered on the request channel must be neither 0 nor 2.

Top module: `irq_presenter`

Register operation codes on `reg_op`: 0 idle, 1 acknowledge, 2 peek, 3 set processor priority (`reg_wdata[7:0]`), 4 set inter-processor priority (`reg_wdata[7:0]`), 5 completion (`reg_wdata[31:24]` is the new processor priority and `reg_wdata[23:0]` is the finished source). Back-pressure rule: `req_ready` is high exactly when `reg_op` is 0. An offer counts only in a cycle where `req_valid` and `req_ready` are both high, and `req_src`/`req_prio` must stay stable while `req_valid` is high and `req_ready` is low. Every output is registered and appears one cycle after the operation or handshake that causes it.

## Requirements
- R1: After reset, the pending word reads 0, the pending priority and the inter-processor priority are 0xFF, and `irq_out`, `rsp_valid`, `bounce_valid`, `eoi_valid`, `resend_req` and `rd_valid` are low.
- R2: An offer with priority p is refused (`rsp_accept`=0) when p >= processor priority, or when the slot holds a source whose priority is <= p. Otherwise it is admitted (`rsp_accept`=1) and stored. The answer comes one cycle after the handshake and carries the offered source number.
- R3: When an admitted offer or an inter-processor claim displaces a pending source, that source is reported on `bounce_src` with `bounce_valid` in the same response cycle. A displaced inter-processor entry (number 2) is dropped without a bounce.
- R4: Acknowledge (op 1) returns the pending word as it was before the operation, together with the inter-processor priority. It then sets the processor priority to the pending priority, empties the slot, sets the pending priority to 0xFF and lowers `irq_out`.
- R5: Peek (op 2) returns the pending word and the inter-processor priority and changes no state.
- R6: Setting a processor priority below the old one, while the slot holds a source whose pending priority is >= the new value, empties the slot, sets the pending priority to 0xFF, lowers `irq_out` and bounces that source.
- R7: Setting a processor priority that is not below the old one while the slot is empty performs a resend. A resend first makes an inter-processor claim if the inter-processor priority is below the processor priority, and then pulses `resend_req`.
- R8: Setting the inter-processor priority below the processor priority makes a claim unless the slot holds an entry with priority <= the new value. A claim stores source 2 with the inter-processor priority and raises `irq_out`.
- R9: Completion (op 5) loads the processor priority from `reg_wdata[31:24]`, emits `reg_wdata[23:0]` on `eoi_src` with `eoi_valid`, and performs a resend when the slot is empty.
- R10: `irq_out` is high exactly when the slot holds a nonzero source, and `req_ready` is low in any cycle that carries a register operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Offer from the source controller is valid |
| req_ready | output | 1 | Offer can be taken this cycle |
| req_src | input | 24 | Offered source number |
| req_prio | input | 8 | Offered priority |
| rsp_valid | output | 1 | Answer to an offer is valid |
| rsp_accept | output | 1 | 1 admitted, 0 refused |
| rsp_src | output | 24 | Source number the answer refers to |
| bounce_valid | output | 1 | A displaced source is returned |
| bounce_src | output | 24 | Displaced source number |
| reg_op | input | 3 | Register operation code |
| reg_wdata | input | 32 | Write data for register operations |
| rd_valid | output | 1 | Read result of acknowledge or peek is valid |
| rd_data | output | 32 | Pending word read |
| rd_ipi_prio | output | 8 | Inter-processor priority read |
| eoi_valid | output | 1 | Completion forwarded to the sources |
| eoi_src | output | 24 | Completed source number |
| resend_req | output | 1 | Pulse asking the sources to resend refused offers |
| irq_out | output | 1 | Interrupt line to the core |

## Verification
A corrupted pending priority or slot stays invisible until a later offer gets the wrong admit or refuse answer, or until an acknowledge or peek returns the word, so the bench interleaves peeks with random traffic and exposes such faults within a few operations. A wrong processor priority shows up on the next offer near the threshold, or on a later acknowledge. A missed bounce or an extra bounce is seen at once on the bounce port, in the cycle after the displacing event. Losing the inter-processor request shows up on `irq_out` one cycle after the write or resend that should have claimed the slot.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_ACK      = 3'd1,
    OP_PEEK     = 3'd2,
    OP_SET_CUR  = 3'd3,
    OP_SET_IPI  = 3'd4,
    OP_DONE     = 3'd5
  } reg_op_e;
endpackage

// File: rtl/irqp_offer_eval.sv
module irqp_offer_eval #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8,
  parameter int IPI_SRC = 2
) (
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [SRC_W-1:0]  slot_src,
  input  logic [PRIO_W-1:0] slot_prio,
  input  logic [PRIO_W-1:0] offer_prio,
  output logic              admit,
  output logic              displace
);
  logic slot_busy;
  assign slot_busy = (slot_src != '0);
  assign admit     = (offer_prio < cur_prio) && !(slot_busy && (slot_prio <= offer_prio));
  assign displace  = admit && slot_busy && (slot_src != SRC_W'(IPI_SRC));
endmodule

// File: rtl/irqp_ipi_eval.sv
module irqp_ipi_eval #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8,
  parameter int IPI_SRC = 2
) (
  input  logic [SRC_W-1:0]  slot_src,
  input  logic [PRIO_W-1:0] slot_prio,
  input  logic [PRIO_W-1:0] ipi_prio,
  output logic              take,
  output logic              displace
);
  logic slot_busy;
  assign slot_busy = (slot_src != '0);
  assign take      = !(slot_busy && (slot_prio <= ipi_prio));
  assign displace  = take && slot_busy && (slot_src != SRC_W'(IPI_SRC));
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [SRC_W-1:0]         req_src,
  input  logic [PRIO_W-1:0]        req_prio,
  output logic                     rsp_valid,
  output logic                     rsp_accept,
  output logic [SRC_W-1:0]         rsp_src,
  output logic                     bounce_valid,
  output logic [SRC_W-1:0]         bounce_src,
  input  logic [2:0]               reg_op,
  input  logic [PRIO_W+SRC_W-1:0]  reg_wdata,
  output logic                     rd_valid,
  output logic [PRIO_W+SRC_W-1:0]  rd_data,
  output logic [PRIO_W-1:0]        rd_ipi_prio,
  output logic                     eoi_valid,
  output logic [SRC_W-1:0]         eoi_src,
  output logic                     resend_req,
  output logic                     irq_out
);
  import irqp_pkg::*;

  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] MASKED = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM = SRC_W'(IPI_SRC);

  reg_op_e op;
  assign op = reg_op_e'(reg_op);

  logic [PRIO_W-1:0] cur_q, pend_q, ipi_q;
  logic [SRC_W-1:0]  src_q;
  logic [PRIO_W-1:0] cur_n, pend_n, ipi_n;
  logic [SRC_W-1:0]  src_n;

  logic              rsp_v_n, rsp_acc_n, bnc_v_n, rd_v_n, eoi_v_n, resend_n;
  logic [SRC_W-1:0]  rsp_src_n, bnc_src_n, eoi_src_n;
  logic [WORD_W-1:0] rd_data_n;
  logic [PRIO_W-1:0] rd_ipi_n;

  logic [PRIO_W-1:0] wr_lo, wr_hi;
  assign wr_lo = reg_wdata[PRIO_W-1:0];
  assign wr_hi = reg_wdata[WORD_W-1:SRC_W];

  // offer decision
  logic offer_admit, offer_disp;
  irqp_offer_eval #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_offer (
    .cur_prio  (cur_q),
    .slot_src  (src_q),
    .slot_prio (pend_q),
    .offer_prio(req_prio),
    .admit     (offer_admit),
    .displace  (offer_disp)
  );

  // inter-processor claim decision
  logic [PRIO_W-1:0] ipi_sel;
  logic              ipi_take, ipi_disp;
  assign ipi_sel = (op == OP_SET_IPI) ? wr_lo : ipi_q;
  irqp_ipi_eval #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_ipi (
    .slot_src (src_q),
    .slot_prio(pend_q),
    .ipi_prio (ipi_sel),
    .take     (ipi_take),
    .displace (ipi_disp)
  );

  assign req_ready = (op == OP_IDLE);

  logic do_resend, ipi_try;

  always_comb begin
    cur_n     = cur_q;
    pend_n    = pend_q;
    ipi_n     = ipi_q;
    src_n     = src_q;
    rsp_v_n   = 1'b0;
    rsp_acc_n = 1'b0;
    rsp_src_n = req_src;
    bnc_v_n   = 1'b0;
    bnc_src_n = src_q;
    rd_v_n    = 1'b0;
    rd_data_n = {cur_q, src_q};
    rd_ipi_n  = ipi_q;
    eoi_v_n   = 1'b0;
    eoi_src_n = reg_wdata[SRC_W-1:0];
    resend_n  = 1'b0;
    do_resend = 1'b0;
    ipi_try   = 1'b0;
    case (op)
      OP_ACK: begin
        rd_v_n = 1'b1;
        cur_n  = pend_q;
        src_n  = '0;
        pend_n = MASKED;
      end
      OP_PEEK: begin
        rd_v_n = 1'b1;
      end
      OP_SET_CUR: begin
        cur_n = wr_lo;
        if (wr_lo < cur_q) begin
          if ((src_q != '0) && (wr_lo <= pend_q)) begin
            src_n  = '0;
            pend_n = MASKED;
            bnc_v_n = (src_q != IPI_NUM);
          end
        end else if (src_q == '0) begin
          do_resend = 1'b1;
        end
      end
      OP_SET_IPI: begin
        ipi_n = wr_lo;
        if (wr_lo < cur_q) ipi_try = 1'b1;
      end
      OP_DONE: begin
        cur_n   = wr_hi;
        eoi_v_n = 1'b1;
        if (src_q == '0) do_resend = 1'b1;
      end
      OP_IDLE: begin
        if (req_valid) begin
          rsp_v_n = 1'b1;
          if (offer_admit) begin
            rsp_acc_n = 1'b1;
            bnc_v_n   = offer_disp;
            src_n     = req_src;
            pend_n    = req_prio;
          end
        end
      end
      default: ;
    endcase
    if (do_resend) begin
      resend_n = 1'b1;
      if (ipi_q < cur_n) ipi_try = 1'b1;
    end
    if (ipi_try && ipi_take) begin
      bnc_v_n = ipi_disp;
      src_n   = IPI_NUM;
      pend_n  = ipi_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q        <= '0;
      src_q        <= '0;
      pend_q       <= MASKED;
      ipi_q        <= MASKED;
      irq_out      <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_accept   <= 1'b0;
      rsp_src      <= '0;
      bounce_valid <= 1'b0;
      bounce_src   <= '0;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      rd_ipi_prio  <= MASKED;
      eoi_valid    <= 1'b0;
      eoi_src      <= '0;
      resend_req   <= 1'b0;
    end else begin
      cur_q        <= cur_n;
      src_q        <= src_n;
      pend_q       <= pend_n;
      ipi_q        <= ipi_n;
      irq_out      <= (src_n != '0);
      rsp_valid    <= rsp_v_n;
      rsp_accept   <= rsp_acc_n;
      rsp_src      <= rsp_src_n;
      bounce_valid <= bnc_v_n;
      bounce_src   <= bnc_src_n;
      rd_valid     <= rd_v_n;
      rd_data      <= rd_data_n;
      rd_ipi_prio  <= rd_ipi_n;
      eoi_valid    <= eoi_v_n;
      eoi_src      <= eoi_src_n;
      resend_req   <= resend_n;
    end
  end

  // R2
  rsp_after_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));
  // R2
  admit_fills_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_accept) |-> (src_q == rsp_src) && irq_out);
  // R3
  bounce_not_ipi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bounce_valid |-> (bounce_src != IPI_NUM) && (bounce_src != '0));
  // R4
  ack_drops_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ACK) |=> (!irq_out && rd_valid && (pend_q == MASKED)));
  // R5
  peek_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PEEK) |=> ($stable(cur_q) && $stable(src_q) && $stable(pend_q) && $stable(ipi_q)));
  // R9
  done_loads_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DONE) |=> (eoi_valid && (cur_q == $past(wr_hi))));
endmodule

// File: tb/irq_presenter_test.sv
module irq_presenter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_src;
  logic [7:0]  req_prio;
  logic        rsp_valid, rsp_accept;
  logic [23:0] rsp_src;
  logic        bounce_valid;
  logic [23:0] bounce_src;
  logic [2:0]  reg_op;
  logic [31:0] reg_wdata;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [7:0]  rd_ipi_prio;
  logic        eoi_valid;
  logic [23:0] eoi_src;
  logic        resend_req;
  logic        irq_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_presenter uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src), .req_prio(req_prio),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_src(rsp_src),
    .bounce_valid(bounce_valid), .bounce_src(bounce_src),
    .reg_op(reg_op), .reg_wdata(reg_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ipi_prio(rd_ipi_prio),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req), .irq_out(irq_out)
  );

  int checks = 0;
  int errors = 0;

  // expected state
  logic [7:0]  m_cur, m_pend, m_ipi;
  logic [23:0] m_src;
  // expected outputs of one step
  logic e_rsp_v, e_rsp_acc, e_bnc_v, e_rd_v, e_eoi_v, e_resend;
  logic [23:0] e_rsp_src, e_bnc_src, e_eoi_src;
  logic [31:0] e_rd_data;
  logic [7:0]  e_rd_ipi;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_ipi_claim(input logic [7:0] p);
    if (!((m_src != 0) && (m_pend <= p))) begin
      if ((m_src != 0) && (m_src != 24'd2)) begin
        e_bnc_v = 1'b1; e_bnc_src = m_src;
      end
      m_src = 24'd2; m_pend = p;
    end
  endtask

  task automatic model_resend();
    e_resend = 1'b1;
    if (m_ipi < m_cur) model_ipi_claim(m_ipi);
  endtask

  task automatic model(input logic [2:0] op, input logic [31:0] wd,
                       input logic rv, input logic [23:0] rs, input logic [7:0] rp);
    logic [7:0] w8;
    w8 = wd[7:0];
    e_rsp_v = 0; e_rsp_acc = 0; e_rsp_src = rs; e_bnc_v = 0; e_bnc_src = 0;
    e_rd_v = 0; e_rd_data = {m_cur, m_src}; e_rd_ipi = m_ipi;
    e_eoi_v = 0; e_eoi_src = wd[23:0]; e_resend = 0;
    case (op)
      3'd1: begin e_rd_v = 1; m_cur = m_pend; m_src = 0; m_pend = 8'hFF; end
      3'd2: e_rd_v = 1;
      3'd3: begin
        if (w8 < m_cur) begin
          m_cur = w8;
          if ((m_src != 0) && (w8 <= m_pend)) begin
            if (m_src != 24'd2) begin e_bnc_v = 1; e_bnc_src = m_src; end
            m_src = 0; m_pend = 8'hFF;
          end
        end else begin
          m_cur = w8;
          if (m_src == 0) model_resend();
        end
      end
      3'd4: begin m_ipi = w8; if (w8 < m_cur) model_ipi_claim(w8); end
      3'd5: begin m_cur = wd[31:24]; e_eoi_v = 1; if (m_src == 0) model_resend(); end
      default: if (rv) begin
        e_rsp_v = 1;
        if ((rp < m_cur) && !((m_src != 0) && (m_pend <= rp))) begin
          e_rsp_acc = 1;
          if ((m_src != 0) && (m_src != 24'd2)) begin e_bnc_v = 1; e_bnc_src = m_src; end
          m_src = rs; m_pend = rp;
        end
      end
    endcase
  endtask

  // one cycle: drive at negedge, compare at next negedge
  task automatic step(input logic [2:0] op, input logic [31:0] wd,
                      input logic rv, input logic [23:0] rs, input logic [7:0] rp,
                      input string rd_tag);
    reg_op = op; reg_wdata = wd; req_valid = rv; req_src = rs; req_prio = rp;
    #1;
    check("R10 req_ready", {31'd0, req_ready}, {31'd0, op == 3'd0});
    model(op, wd, rv, rs, rp);
    @(negedge clk);
    check("R2 rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rsp_v});
    if (e_rsp_v) begin
      check("R2 rsp_accept", {31'd0, rsp_accept}, {31'd0, e_rsp_acc});
      check("R2 rsp_src", {8'd0, rsp_src}, {8'd0, e_rsp_src});
    end
    check("R3 bounce_valid", {31'd0, bounce_valid}, {31'd0, e_bnc_v});
    if (e_bnc_v) check("R3 bounce_src", {8'd0, bounce_src}, {8'd0, e_bnc_src});
    check("R9 eoi_valid", {31'd0, eoi_valid}, {31'd0, e_eoi_v});
    if (e_eoi_v) check("R9 eoi_src", {8'd0, eoi_src}, {8'd0, e_eoi_src});
    check("R7 resend_req", {31'd0, resend_req}, {31'd0, e_resend});
    check("R10 irq_out", {31'd0, irq_out}, {31'd0, m_src != 0});
    check("R4 rd_valid", {31'd0, rd_valid}, {31'd0, e_rd_v});
    if (e_rd_v) begin
      check({rd_tag, " rd_data"}, rd_data, e_rd_data);
      check({rd_tag, " rd_ipi_prio"}, {24'd0, rd_ipi_prio}, {24'd0, e_rd_ipi});
    end
  endtask

  task automatic offer(input logic [23:0] s, input logic [7:0] p);
    step(3'd0, 32'd0, 1'b1, s, p, "R2");
  endtask
  task automatic peek(input string tag);
    step(3'd2, 32'd0, 1'b0, 24'd0, 8'd0, tag);
  endtask
  task automatic wr(input logic [2:0] op, input logic [31:0] wd, input string tag);
    step(op, wd, 1'b0, 24'd0, 8'd0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 0; req_valid = 0; req_src = 0; req_prio = 0; reg_op = 0; reg_wdata = 0;
    m_cur = 0; m_src = 0; m_pend = 8'hFF; m_ipi = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq_out", {31'd0, irq_out}, 32'd0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 bounce_valid", {31'd0, bounce_valid}, 32'd0);
    check("R1 resend_req", {31'd0, resend_req}, 32'd0);
    peek("R1");
    // R2: processor priority 0 refuses everything
    offer(24'd10, 8'd3);
    // R7: raise priority with empty slot -> resend
    wr(3'd3, 32'h0000_0080, "R7");
    offer(24'd10, 8'd40);          // admitted
    offer(24'd11, 8'd40);          // equal -> refused (R2)
    offer(24'd12, 8'd20);          // preempts, bounces 10 (R3)
    peek("R5");
    peek("R5");
    // R6: lower current priority below pending -> drop and bounce 12
    wr(3'd3, 32'h0000_0010, "R6");
    peek("R6");
    // R8: inter-processor claim
    wr(3'd3, 32'h0000_0080, "R7");
    offer(24'd13, 8'd50);
    wr(3'd4, 32'h0000_0030, "R8");  // 50 > 0x30 -> claim, bounce 13
    peek("R8");
    offer(24'd14, 8'd5);            // displaces IPI, no bounce (R3)
    step(3'd1, 32'd0, 1'b0, 24'd0, 8'd0, "R4"); // acknowledge
    peek("R4");
    // R9: completion with empty slot -> resend, IPI reclaims
    wr(3'd5, 32'h8000_000E, "R9");
    peek("R9");
    step(3'd1, 32'd0, 1'b0, 24'd0, 8'd0, "R4");
    wr(3'd4, 32'h0000_00FF, "R8");
    wr(3'd5, 32'hFF00_0002, "R9");
    peek("R9");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int unsigned k;
      logic [7:0] p;
      logic [23:0] s;
      k = $urandom_range(0, 15);
      p = ($urandom_range(0, 7) == 0) ? 8'hFF : 8'($urandom_range(0, 12));
      s = 24'($urandom_range(3, 60));
      case (k)
        0, 1:    step(3'd1, 32'd0, 1'b0, 24'd0, 8'd0, "R4");
        2, 3:    peek("R5");
        4:       wr(3'd3, {24'd0, p}, "R6");
        5:       wr(3'd4, {24'd0, p}, "R8");
        6:       wr(3'd5, {p, s}, "R9");
        7:       step(3'd0, 32'd0, 1'b0, s, p, "R2");
        default: offer(s, p);
      endcase
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule